// File: doc/BRIEF.md
# Packet Buffer Memory Manager

This block keeps track of a pool of numbered packet buffers for a network interface. A host writes 3-bit opcodes to a command port. The manager uses them to allocate a buffer number for transmit, free buffer numbers, return everything to its initial state, take packet numbers off the receive queue and put packet numbers on the transmit queue. A packet-number register, written through its own strobe, holds the operand for the release and enqueue commands. A receive engine hands over completed packet numbers through a push port. A transmit engine reads the head of the transmit queue and consumes entries with a pop strobe. The packet RAM itself and the MAC datapath are outside this block.

Most commands finish at the clock edge that accepts them. The two commands that free memory by number walk the whole pool, one entry per cycle. While they run, the `busy` output is high and any further command write is dropped. The controller has two states. `ST_IDLE` accepts commands. `ST_SCAN` walks the pool.
- `ST_IDLE` moves to `ST_SCAN` when a pop-and-free command is accepted with the receive queue non-empty, or when a release command is accepted.
- `ST_SCAN` returns to `ST_IDLE` on the cycle that visits the last pool entry.
- Every other accepted command keeps the controller in `ST_IDLE`.

Top module: `pktbuf_mgr`

## Requirements
- R1: A write of opcode 0 or opcode 7 changes no output and no internal state.
- R2: Opcode 1 marks the lowest-numbered free buffer as used. In the cycle after the accepting edge, `alloc_num` shows that number, `alloc_fail` is 0 and `alloc_int` is 1. `busy` stays low.
- R3: Opcode 1 with no free buffer sets `alloc_fail` to 1. It leaves `alloc_num`, `alloc_int` and the map unchanged.
- R4: Opcode 2 frees every buffer. It empties both queues, so `rx_int` and `tx_valid` go low. It clears `alloc_num`, `alloc_fail` and `alloc_int`. The packet-number register keeps its value.
- R5: Opcode 3 removes the head of the receive queue without freeing it, and the next number appears on `rx_head`. On an empty queue it does nothing.
- R6: Opcode 4 with a non-empty receive queue removes the head and frees that number. `busy` is high for exactly POOL_N cycles. On an empty queue it does nothing and `busy` stays low.
- R7: Opcode 5 frees the number held in the packet-number register. `busy` is high for exactly POOL_N cycles.
- R8: Opcode 6 appends the packet-number register value to the transmit queue, which holds Q_DEPTH entries. A push on a full queue is dropped.
- R9: A command write while `busy` is high is ignored.
- R10: `rx_int` is high exactly while the receive queue holds a number. It goes low when the last one is removed.
- R11: `rx_push` appends `rx_pnum` to the receive queue and marks that number used. When the queue is full, `rx_ready` is low and the push is dropped.
- R12: `tx_pop` removes the head of the transmit queue, so numbers leave in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 3 | Command opcode |
| pnum_wr | input | 1 | Packet-number register write strobe |
| pnum_wdata | input | PNW | Packet-number register write value |
| rx_push | input | 1 | Receive engine pushes a completed packet number |
| rx_pnum | input | PNW | Packet number being pushed |
| tx_pop | input | 1 | Transmit engine consumes the head of the transmit queue |
| busy | output | 1 | A multi-cycle command is running |
| alloc_num | output | PNW | Number returned by the last successful allocation |
| alloc_fail | output | 1 | The last allocation found no free buffer |
| alloc_int | output | 1 | Allocation-done interrupt |
| rx_head | output | PNW | Head of the receive queue |
| rx_int | output | 1 | Receive queue is non-empty |
| rx_ready | output | 1 | Receive queue can accept a push |
| tx_head | output | PNW | Head of the transmit queue |
| tx_valid | output | 1 | Transmit queue is non-empty |

## Verification
The bench builds the block with its default values: a 16-number pool and two 16-deep queues. With these values, seventeen allocations are enough to exhaust the pool and show the failure flag. Seventeen pushes are enough to hit the drop rule on either queue. Each release scan is short enough that its busy window can be counted exactly, and many can be run amid random traffic.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ALLOC   = 3'd1,
        OP_RESET   = 3'd2,
        OP_RXPOP   = 3'd3,
        OP_RXFREE  = 3'd4,
        OP_RELEASE = 3'd5,
        OP_TXPUSH  = 3'd6,
        OP_SPARE   = 3'd7
    } mgr_op_e;

    typedef enum logic {
        ST_IDLE,
        ST_SCAN
    } mgr_state_e;

endpackage

// File: rtl/pktbuf_queue.sv
module pktbuf_queue #(
    parameter int W     = 4,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp;
    logic [AW:0]  rp;
    logic         push_ok;
    logic         pop_ok;

    assign empty   = (wp == rp);
    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign push_ok = push && !full && !clear;
    assign pop_ok  = pop && !empty && !clear;
    assign head    = mem[rp[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (clear) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp[AW-1:0]] <= push_data;
    end

    // R8
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> full);

    // R5
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clear) |=> empty);

endmodule

// File: rtl/pktbuf_pool.sv
module pktbuf_pool #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          alloc_en,
    input  logic          mark_en,
    input  logic [IW-1:0] mark_idx,
    input  logic          rel_en,
    input  logic [IW-1:0] rel_idx,
    output logic [IW-1:0] free_idx,
    output logic          any_free
);
    logic [N-1:0] used;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used <= '0;
        end else if (clr_all) begin
            used <= '0;
        end else begin
            if (rel_en)              used[rel_idx]  <= 1'b0;
            if (alloc_en && any_free) used[free_idx] <= 1'b1;
            if (mark_en)             used[mark_idx] <= 1'b1;
        end
    end

    // lowest free entry wins: scan from the top so the last hit is the lowest
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                any_free = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    // R2
    alloc_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && any_free && !clr_all && !rel_en) |=> (!any_free || free_idx != $past(free_idx)));

endmodule

// File: rtl/pktbuf_mgr.sv
module pktbuf_mgr
    import pktbuf_pkg::*;
#(
    parameter int POOL_N  = 16,
    parameter int Q_DEPTH = 16,
    parameter int PNW     = $clog2(POOL_N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_wr,
    input  logic [2:0]     cmd_op,
    input  logic           pnum_wr,
    input  logic [PNW-1:0] pnum_wdata,
    input  logic           rx_push,
    input  logic [PNW-1:0] rx_pnum,
    input  logic           tx_pop,
    output logic           busy,
    output logic [PNW-1:0] alloc_num,
    output logic           alloc_fail,
    output logic           alloc_int,
    output logic [PNW-1:0] rx_head,
    output logic           rx_int,
    output logic           rx_ready,
    output logic [PNW-1:0] tx_head,
    output logic           tx_valid
);
    localparam logic [PNW-1:0] LAST_IDX = PNW'(POOL_N - 1);

    mgr_state_e     state, state_nx;
    logic [PNW-1:0] scan_idx;
    logic [PNW-1:0] target;
    logic [PNW-1:0] pnum_q;
    logic           accept;
    logic           do_alloc, do_reset, do_rxpop, do_rxfree, do_release, do_txpush;
    logic           rx_empty, rx_full, tx_empty, tx_full;
    logic           scan_last, rel_en;
    logic [PNW-1:0] free_idx;
    logic           any_free;

    assign accept     = cmd_wr && (state == ST_IDLE);
    assign do_alloc   = accept && (cmd_op == OP_ALLOC);
    assign do_reset   = accept && (cmd_op == OP_RESET);
    assign do_rxfree  = accept && (cmd_op == OP_RXFREE) && !rx_empty;
    assign do_rxpop   = (accept && (cmd_op == OP_RXPOP)) || do_rxfree;
    assign do_release = accept && (cmd_op == OP_RELEASE);
    assign do_txpush  = accept && (cmd_op == OP_TXPUSH);
    assign scan_last  = (scan_idx == LAST_IDX);
    assign rel_en     = (state == ST_SCAN) && (scan_idx == target);

    assign busy     = (state == ST_SCAN);
    assign rx_int   = !rx_empty;
    assign rx_ready = !rx_full;
    assign tx_valid = !tx_empty;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (do_rxfree || do_release) state_nx = ST_SCAN;
            ST_SCAN: if (scan_last)               state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            scan_idx <= '0;
            target   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE) begin
                scan_idx <= '0;
                if (do_rxfree)       target <= rx_head;
                else if (do_release) target <= pnum_q;
            end else begin
                scan_idx <= scan_idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pnum_q     <= '0;
            alloc_num  <= '0;
            alloc_fail <= 1'b0;
            alloc_int  <= 1'b0;
        end else begin
            if (pnum_wr) pnum_q <= pnum_wdata;
            if (do_reset) begin
                alloc_num  <= '0;
                alloc_fail <= 1'b0;
                alloc_int  <= 1'b0;
            end else if (do_alloc) begin
                if (any_free) begin
                    alloc_num  <= free_idx;
                    alloc_fail <= 1'b0;
                    alloc_int  <= 1'b1;
                end else begin
                    alloc_fail <= 1'b1;
                end
            end
        end
    end

    pktbuf_pool #(.N(POOL_N), .IW(PNW)) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (do_reset),
        .alloc_en (do_alloc),
        .mark_en  (rx_push && !rx_full && !do_reset),
        .mark_idx (rx_pnum),
        .rel_en   (rel_en),
        .rel_idx  (scan_idx),
        .free_idx (free_idx),
        .any_free (any_free)
    );

    pktbuf_queue #(.W(PNW), .DEPTH(Q_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_reset),
        .push      (rx_push),
        .push_data (rx_pnum),
        .pop       (do_rxpop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    pktbuf_queue #(.W(PNW), .DEPTH(Q_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_reset),
        .push      (do_txpush),
        .push_data (pnum_q),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(alloc_num) && $stable(alloc_int) && $stable(alloc_fail)));

    // R6
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && scan_last) |=> !busy);

    // R7
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr && (cmd_op == 3'd4 || cmd_op == 3'd5)));

    // R4
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == 3'd2) |=> (!rx_int && !tx_valid && !alloc_int && !alloc_fail));

    // R10
    rx_int_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_int) |-> $past(accept && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4)));

endmodule

// File: tb/sim_pktbuf_mgr.sv
module sim_pktbuf_mgr;
    localparam int POOL = 16;
    localparam int QD   = 16;
    localparam int PW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic          pnum_wr = 1'b0;
    logic [PW-1:0] pnum_wdata = '0;
    logic          rx_push = 1'b0;
    logic [PW-1:0] rx_pnum = '0;
    logic          tx_pop = 1'b0;
    logic          busy, alloc_fail, alloc_int, rx_int, rx_ready, tx_valid;
    logic [PW-1:0] alloc_num, rx_head, tx_head;

    always #4 clk = ~clk;

    pktbuf_mgr #(.POOL_N(POOL), .Q_DEPTH(QD)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
        .pnum_wr(pnum_wr), .pnum_wdata(pnum_wdata), .rx_push(rx_push),
        .rx_pnum(rx_pnum), .tx_pop(tx_pop), .busy(busy), .alloc_num(alloc_num),
        .alloc_fail(alloc_fail), .alloc_int(alloc_int), .rx_head(rx_head),
        .rx_int(rx_int), .rx_ready(rx_ready), .tx_head(tx_head), .tx_valid(tx_valid)
    );

    bit used_m [POOL];
    int txq [$];
    int rxq [$];
    int m_num, m_pnum;
    bit m_fail, m_int;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "busy", int'(busy), 0);
        check(req, "alloc_num", int'(alloc_num), m_num);
        check(req, "alloc_fail", int'(alloc_fail), int'(m_fail));
        check(req, "alloc_int", int'(alloc_int), int'(m_int));
        check(req, "rx_int", int'(rx_int), int'(rxq.size() > 0));
        check(req, "rx_ready", int'(rx_ready), int'(rxq.size() < QD));
        if (rxq.size() > 0) check(req, "rx_head", int'(rx_head), rxq[0]);
        check(req, "tx_valid", int'(tx_valid), int'(txq.size() > 0));
        if (txq.size() > 0) check(req, "tx_head", int'(tx_head), txq[0]);
    endtask

    function automatic int model_busy(int op);
        if (op == 5) return POOL;
        if (op == 4 && rxq.size() > 0) return POOL;
        return 0;
    endfunction

    task automatic model_cmd(int op);
        int n;
        case (op)
            1: begin
                n = -1;
                for (int i = POOL - 1; i >= 0; i--) if (!used_m[i]) n = i;
                if (n >= 0) begin
                    used_m[n] = 1; m_num = n; m_fail = 0; m_int = 1;
                end else m_fail = 1;
            end
            2: begin
                for (int i = 0; i < POOL; i++) used_m[i] = 0;
                txq.delete(); rxq.delete();
                m_num = 0; m_fail = 0; m_int = 0;
            end
            3: if (rxq.size() > 0) n = rxq.pop_front();
            4: if (rxq.size() > 0) begin n = rxq.pop_front(); used_m[n] = 0; end
            5: used_m[m_pnum] = 0;
            6: if (txq.size() < QD) txq.push_back(m_pnum);
            default: ;
        endcase
    endtask

    task automatic do_cmd(string req, int op);
        int exp_busy, cyc;
        exp_busy = model_busy(op);
        @(negedge clk);
        cmd_op = 3'(op); cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        model_cmd(op);
        check(req, "busy cycles", cyc, exp_busy);
        check_all(req);
    endtask

    task automatic set_pnum(int v);
        @(negedge clk);
        pnum_wr = 1'b1; pnum_wdata = PW'(v);
        @(negedge clk);
        pnum_wr = 1'b0;
        m_pnum = v;
    endtask

    task automatic push_rx(string req, int v);
        @(negedge clk);
        rx_push = 1'b1; rx_pnum = PW'(v);
        @(negedge clk);
        rx_push = 1'b0;
        if (rxq.size() < QD) begin rxq.push_back(v); used_m[v] = 1; end
        check_all(req);
    endtask

    task automatic pop_tx(string req);
        int n;
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        if (txq.size() > 0) n = txq.pop_front();
        check_all(req);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        int r, v, cyc;
        seed = $urandom(32'd20240611);
        m_num = 0; m_pnum = 0; m_fail = 0; m_int = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R4");

        // R2 lowest-free allocation, R3 exhaustion
        for (int i = 0; i < POOL; i++) do_cmd("R2", 1);
        do_cmd("R3", 1);
        do_cmd("R3", 1);

        // R7 release a specific number, then it is the lowest free again
        set_pnum(5);
        do_cmd("R7", 5);
        do_cmd("R7", 1);
        check("R7", "realloc number", int'(alloc_num), 5);

        // R1 opcodes 0 and 7
        do_cmd("R1", 0);
        do_cmd("R1", 7);
        do_cmd("R1", 1);

        // R4 reset command, R11 receive pushes, R5/R6 receive pops
        do_cmd("R4", 2);
        push_rx("R11", 9);
        push_rx("R11", 2);
        push_rx("R11", 11);
        do_cmd("R11", 1);
        do_cmd("R5", 3);
        check("R5", "rx_head after pop", int'(rx_head), 2);
        do_cmd("R6", 4);
        do_cmd("R6", 1);
        do_cmd("R6", 1);
        check("R6", "freed number reused", int'(alloc_num), 2);
        do_cmd("R10", 3);
        check("R10", "rx_int after last pop", int'(rx_int), 0);
        do_cmd("R5", 3);
        do_cmd("R6", 4);

        // R8 fill transmit queue past depth, R12 drain in order
        for (int i = 0; i <= QD; i++) begin
            set_pnum(i % POOL);
            do_cmd("R8", 6);
        end
        for (int i = 0; i <= QD; i++) pop_tx("R12");

        // R11 receive queue full
        for (int i = 0; i <= QD; i++) push_rx("R11", (i * 7) % POOL);
        check("R11", "rx_ready when full", int'(rx_ready), 0);
        do_cmd("R4", 2);

        // R9 writes during a scan are dropped
        set_pnum(3);
        @(negedge clk);
        cmd_op = 3'd5; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_op = 3'd6;
        @(negedge clk);
        cmd_op = 3'd1;
        repeat (3) @(negedge clk);
        cmd_op = 3'd2;
        @(negedge clk);
        cmd_wr = 1'b0;
        cyc = 0;
        while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
        model_cmd(5);
        check("R9", "busy cycles", cyc + 5, POOL);
        check_all("R9");

        // random traffic, all requirements
        for (int k = 0; k < 500; k++) begin
            r = int'($urandom % 10);
            v = int'($urandom % POOL);
            if (r < 6) do_cmd("R2-mix", int'($urandom % 8));
            else if (r == 6) push_rx("R11", v);
            else if (r == 7) pop_tx("R12");
            else set_pnum(v);
        end
        do_cmd("R4", 2);
        finish_run();
    end
endmodule